// File: doc/BRIEF.md
# Timer Register Front End with Deferred Reload and Compare Loads

This block is the register interface of a small timer and counter core. Software reaches it through a single request channel that carries reads and writes. The block holds the values that steer the counting logic: an on/off control with a start-continuous bit, the input configuration (quadrature versus plain counting, active edge selection and a prescaler), the reload limit and the compare value. It also reports the live count that the core supplies.

Loads of the reload and compare values are only honoured while the timer is switched on. Each honoured load passes through a fixed two-cycle transfer path, which stands in for the crossing into the counter clock. When the load lands, the block raises a sticky done flag. Software polls that flag and later clears it by writing ones to a separate clear register. The configuration is locked while the timer runs.

The request channel uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while any load is still in transfer. During that time the requester must hold its request stable. Each accepted read returns its data with `rsp_valid` exactly one cycle later. There is no back-pressure on the response side.

Top module: `tmr_regif`

## Requirements
- R1: After reset, the outputs are as follows. Status bits are 0, enable and run are 0, every configuration field is 0, the applied reload value is all ones and the applied compare value is 0.
- R2: Word addresses are: 0 status (read only), 1 flag clear (write only), 2 control, 3 configuration, 4 reload, 5 compare, 6 count (read only). A configuration write while disabled loads bit 0 into encoder mode, bit 1 into count mode, bits 3:2 into polarity and bits 6:4 into the prescaler, and the register reads back in the same layout.
- R3: A configuration write while enabled leaves every configuration field unchanged.
- R4: A reload or compare write while disabled is dropped. The applied value stays as it was and no status bit is set.
- R5: A reload or compare write while enabled works as follows. The applied value and the status bit (bit 1 for reload, bit 0 for compare) change exactly two clock edges after the accepting edge, and not before.
- R6: Status bits stay set until a clear write with a 1 in the matching bit position. Clear bits written as 0 leave their flags untouched.
- R7: A control write with bit 0 and bit 1 both set starts continuous counting (run) only if the timer was already enabled before that write. Otherwise run stays 0, even when the same write turns the timer on.
- R8: A control write with bit 0 clear turns off both enable and run. Control reads back as {run, enable} in bits 1:0.
- R9: A read of the count register returns the count input, sampled at the accepting edge and zero-extended.
- R10: `req_ready` is low from the edge that accepts an honoured load until that load lands. Every accepted read produces `rsp_valid` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| cnt_i | input | CNT_W | Live count from the counter core |
| tmr_en_o | output | 1 | Timer enabled |
| tmr_run_o | output | 1 | Continuous counting started |
| enc_mode_o | output | 1 | Quadrature encoder mode |
| cnt_mode_o | output | 1 | External-edge count mode |
| pol_o | output | 2 | Active edge select |
| presc_o | output | PRE_W | Prescaler select |
| arr_o | output | CNT_W | Applied reload value |
| cmp_o | output | CNT_W | Applied compare value |
| stat_o | output | 2 | Done flags: bit 0 compare, bit 1 reload |

## Verification
The assertions rely on the requester following the valid/ready rule. Loads are issued only when `req_ready` is high. Addresses stay within the seven decoded words, and no clear write can coincide with a landing load. The stimulus meets these conditions by design. Every access waits for `req_ready` at a falling edge, and after each write the bench idles for three cycles, so a transfer always finishes before the next request. Random addresses are drawn from the writable words only.

// File: rtl/tmr_reg_pkg.sv
package tmr_reg_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ARR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd6;
  localparam int NCH = 2;     // channel 0 = compare, channel 1 = reload
  localparam int CH_CMP = 0;
  localparam int CH_ARR = 1;
endpackage

// File: rtl/tmr_xfer.sv
module tmr_xfer #(
  parameter int W = 16,
  parameter int SYNC = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         clr_i,
  output logic [W-1:0] val_o,
  output logic         busy_o,
  output logic         done_o
);
  logic [W-1:0]    stage_q;
  logic [SYNC-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      pipe_q  <= '0;
      val_o   <= RST_VAL;
      done_o  <= 1'b0;
    end else begin
      if (load_i) stage_q <= data_i;
      pipe_q <= (pipe_q << 1) | SYNC'(load_i);
      if (pipe_q[SYNC-1]) begin
        val_o  <= stage_q;
        done_o <= 1'b1;
      end else if (clr_i) begin
        done_o <= 1'b0;
      end
    end
  end

  assign busy_o = |pipe_q;

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !clr_i) |=> done_o);
  assert_val_only_on_land_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(val_o));
endmodule

// File: rtl/tmr_ctl.sv
module tmr_ctl #(
  parameter int PRE_W = 3,
  localparam int CFG_W = 4 + PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl_i,
  input  logic             wr_cfg_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic             en_o,
  output logic             run_o,
  output logic [CFG_W-1:0] cfg_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o  <= 1'b0;
      run_o <= 1'b0;
      cfg_o <= '0;
    end else begin
      if (wr_ctrl_i) begin
        if (!wdata_i[0]) begin
          en_o  <= 1'b0;
          run_o <= 1'b0;
        end else begin
          en_o <= 1'b1;
          if (wdata_i[1] && en_o) run_o <= 1'b1;
        end
      end
      if (wr_cfg_i && !en_o) cfg_o <= wdata_i;
    end
  end

  assert_run_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> en_o);
  assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |=> $stable(cfg_o));
  assert_off_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl_i && !wdata_i[0]) |=> (!en_o && !run_o));
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_reg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W = 16,
  parameter int PRE_W = 3,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              tmr_en_o,
  output logic              tmr_run_o,
  output logic              enc_mode_o,
  output logic              cnt_mode_o,
  output logic [1:0]        pol_o,
  output logic [PRE_W-1:0]  presc_o,
  output logic [CNT_W-1:0]  arr_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [NCH-1:0]    stat_o
);
  localparam int CFG_W = 4 + PRE_W;
  localparam logic [ADDR_W-1:0] CH_ADDR [NCH] = '{A_CMP, A_ARR};

  logic acc, wr, rd;
  logic [CFG_W-1:0] cfg;
  logic [NCH-1:0] busy;
  logic [CNT_W-1:0] val [NCH];
  logic [DATA_W-1:0] rd_mux;

  assign acc = req_valid && req_ready;
  assign wr  = acc && req_write;
  assign rd  = acc && !req_write;
  assign req_ready = ~|busy;

  tmr_ctl #(.PRE_W(PRE_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl_i(wr && req_addr == A_CTRL),
    .wr_cfg_i(wr && req_addr == A_CFG),
    .wdata_i(req_wdata[CFG_W-1:0]),
    .en_o(tmr_en_o), .run_o(tmr_run_o), .cfg_o(cfg)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    tmr_xfer #(
      .W(CNT_W), .SYNC(SYNC),
      .RST_VAL(k == CH_ARR ? {CNT_W{1'b1}} : {CNT_W{1'b0}})
    ) u_xfer (
      .clk(clk), .rst_n(rst_n),
      .load_i(wr && tmr_en_o && req_addr == CH_ADDR[k]),
      .data_i(req_wdata[CNT_W-1:0]),
      .clr_i(wr && req_addr == A_CLR && req_wdata[k]),
      .val_o(val[k]), .busy_o(busy[k]), .done_o(stat_o[k])
    );
  end

  assign cmp_o = val[CH_CMP];
  assign arr_o = val[CH_ARR];
  assign enc_mode_o = cfg[0];
  assign cnt_mode_o = cfg[1];
  assign pol_o      = cfg[3:2];
  assign presc_o    = cfg[CFG_W-1:4];

  always_comb begin
    case (req_addr)
      A_STAT:  rd_mux = DATA_W'(stat_o);
      A_CTRL:  rd_mux = DATA_W'({tmr_run_o, tmr_en_o});
      A_CFG:   rd_mux = DATA_W'(cfg);
      A_ARR:   rd_mux = DATA_W'(arr_o);
      A_CMP:   rd_mux = DATA_W'(cmp_o);
      A_CNT:   rd_mux = DATA_W'(cnt_i);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end

  assert_drop_arr_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_ARR && !tmr_en_o) |=> !busy[CH_ARR]);
  assert_drop_cmp_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_CMP && !tmr_en_o) |=> !busy[CH_CMP]);
  assert_stall_on_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && tmr_en_o && (req_addr == A_ARR || req_addr == A_CMP)) |=> !req_ready);
  assert_read_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  assert_one_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy));
endmodule

// File: tb/sim_tmr_regif.sv
module sim_tmr_regif;
  localparam int DATA_W = 32;
  localparam int CNT_W = 16;
  localparam int PRE_W = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [2:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [CNT_W-1:0] cnt_i = '0;
  logic req_ready, rsp_valid, tmr_en_o, tmr_run_o, enc_mode_o, cnt_mode_o;
  logic [DATA_W-1:0] rsp_rdata;
  logic [1:0] pol_o, stat_o;
  logic [PRE_W-1:0] presc_o;
  logic [CNT_W-1:0] arr_o, cmp_o;

  int total = 0, bad = 0, cycles = 0;

  // bench model
  logic m_en, m_run;
  logic [6:0] m_cfg;
  logic [15:0] m_arr, m_cmp;
  logic [1:0] m_stat;

  always #5 clk = ~clk;

  tmr_regif u0 (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic do_write(logic [2:0] a, logic [31:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic do_read(logic [2:0] a, output logic [31:0] d, output logic v);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  function automatic logic [31:0] model_ctrl(logic [31:0] d);
    if (!d[0]) return 32'd0;
    return {30'd0, m_run | (d[1] & m_en), 1'b1};
  endfunction

  task automatic model_apply(logic [2:0] a, logic [31:0] d);
    logic [31:0] c;
    case (a)
      3'd1: m_stat = m_stat & ~d[1:0];
      3'd2: begin c = model_ctrl(d); m_en = c[0]; m_run = c[1]; end
      3'd3: if (!m_en) m_cfg = d[6:0];
      3'd4: if (m_en) begin m_arr = d[15:0]; m_stat[1] = 1'b1; end
      3'd5: if (m_en) begin m_cmp = d[15:0]; m_stat[0] = 1'b1; end
      default: ;
    endcase
  endtask

  task automatic wr_and_settle(logic [2:0] a, logic [31:0] d);
    do_write(a, d);
    model_apply(a, d);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_model(string req);
    chk(req, {31'd0, tmr_en_o}, {31'd0, m_en});
    chk(req, {31'd0, tmr_run_o}, {31'd0, m_run});
    chk(req, {25'd0, presc_o, pol_o, cnt_mode_o, enc_mode_o}, {25'd0, m_cfg});
    chk(req, {16'd0, arr_o}, {16'd0, m_arr});
    chk(req, {16'd0, cmp_o}, {16'd0, m_cmp});
    chk(req, {30'd0, stat_o}, {30'd0, m_stat});
  endtask

  initial begin
    logic [31:0] rd;
    logic v;
    void'($urandom(32'd20240611));
    m_en = 0; m_run = 0; m_cfg = 0; m_arr = 16'hFFFF; m_cmp = 0; m_stat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_model("R1 reset");
    chk("R1 ready", {31'd0, req_ready}, 32'd1);

    // R2 configuration while disabled
    wr_and_settle(3'd3, 32'h0000_005D);
    chk("R2 cfg enc", {31'd0, enc_mode_o}, 32'd1);
    chk("R2 cfg pol", {30'd0, pol_o}, 32'd3);
    chk("R2 cfg presc", {29'd0, presc_o}, 32'd5);
    do_read(3'd3, rd, v);
    chk("R2 cfg readback", rd, 32'h5D);
    chk("R10 rsp valid", {31'd0, v}, 32'd1);
    @(negedge clk);
    chk("R10 rsp one cycle", {31'd0, rsp_valid}, 32'd0);

    // R4 loads while disabled dropped
    wr_and_settle(3'd4, 32'h1234);
    wr_and_settle(3'd5, 32'h0042);
    chk("R4 arr kept", {16'd0, arr_o}, 32'hFFFF);
    chk("R4 cmp kept", {16'd0, cmp_o}, 32'd0);
    chk("R4 no flag", {30'd0, stat_o}, 32'd0);

    // R7 enable+start together: run stays 0
    wr_and_settle(3'd2, 32'd3);
    chk("R7 start while off", {31'd0, tmr_run_o}, 32'd0);
    chk("R7 enabled", {31'd0, tmr_en_o}, 32'd1);
    wr_and_settle(3'd2, 32'd3);
    chk("R7 start after enable", {31'd0, tmr_run_o}, 32'd1);
    do_read(3'd2, rd, v);
    chk("R8 ctrl readback", rd, 32'd3);

    // R3 cfg locked
    wr_and_settle(3'd3, 32'h0000_0022);
    chk("R3 cfg locked", {25'd0, presc_o, pol_o, cnt_mode_o, enc_mode_o}, 32'h5D);

    // R5 / R10 timing of reload load
    do_write(3'd4, 32'h0ABC);
    chk("R5 arr not yet e0", {16'd0, arr_o}, 32'hFFFF);
    chk("R5 flag not yet e0", {30'd0, stat_o}, 32'd0);
    chk("R10 stall", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R5 arr not yet e1", {16'd0, arr_o}, 32'hFFFF);
    chk("R5 flag not yet e1", {30'd0, stat_o}, 32'd0);
    @(negedge clk);
    chk("R5 arr landed", {16'd0, arr_o}, 32'h0ABC);
    chk("R5 arr flag", {30'd0, stat_o}, 32'd2);
    chk("R10 ready back", {31'd0, req_ready}, 32'd1);
    model_apply(3'd4, 32'h0ABC);
    wr_and_settle(3'd5, 32'h0077);
    chk("R5 cmp landed", {16'd0, cmp_o}, 32'h0077);
    chk("R5 both flags", {30'd0, stat_o}, 32'd3);

    // R6 clear
    wr_and_settle(3'd1, 32'd0);
    chk("R6 zero clear no effect", {30'd0, stat_o}, 32'd3);
    wr_and_settle(3'd1, 32'd1);
    chk("R6 clear cmp only", {30'd0, stat_o}, 32'd2);
    do_read(3'd0, rd, v);
    chk("R6 status read", rd, 32'd2);

    // R9 count
    cnt_i = 16'hBEEF;
    do_read(3'd6, rd, v);
    chk("R9 count read", rd, 32'h0000_BEEF);

    // R8 disable
    wr_and_settle(3'd2, 32'd2);
    chk("R8 disabled", {31'd0, tmr_en_o}, 32'd0);
    chk("R8 run stopped", {31'd0, tmr_run_o}, 32'd0);

    // random mix against model
    for (int i = 0; i < 300; i++) begin
      logic [2:0] a;
      logic [31:0] d;
      a = 3'(1 + ($urandom % 5));
      d = $urandom;
      if ($urandom % 4 == 0) d[0] = 1'b1;
      wr_and_settle(a, d);
      cmp_model("R2-R8 random");
    end

    finish_run();
  end
endmodule